// File: doc/BRIEF.md
# Bulk-Program Streaming Sequencer

This block is the host side of a memory device's bulk-program mode. A client presents a block address, a start address and a word count with a one-cycle go strobe. The sequencer first screens the request. A misaligned or out-of-block request is refused at once, with no bus traffic. An accepted request drives the device over a word-wide bus with separate read and write strobes. The sequencer writes the two mode-entry commands and waits a fixed setup delay. It then streams the payload in groups of exactly 32 words, taking the words from a ready/valid input.

Status is only ever fetched with plain bus reads, because any command word written while the mode is active would be taken as payload. Before each group the sequencer polls until the device reports that it is idle inside the mode and that its buffer is free. A short last group is topped up with all-ones words. After the last group the sequencer waits for the buffer once more and writes outside the block to leave the mode. It then polls until the device reports ready and signals completion. A failure flag in status, or a buffer that never frees up, ends the run early with an error code.

Top module: `bep_stream_host`

## Requirements
- R1: During and right after reset, busy, done, bus_we, bus_re and in_ready are all low.
- R2: A request whose start address has any of bits [4:0] set finishes with err_code 1 on a one-cycle done and causes no bus read or write.
- R3: A request finishes with err_code 2 and no bus cycle if any of these holds: the start address lies in a different block from req_blk (blocks are 2^BLK_W words, selected by the address bits above BLK_W-1), the count is zero, or the start offset inside the block plus the count exceeds 2^BLK_W.
- R4: An accepted request begins with exactly two writes to the start address: 0x0080 and then 0x00D0. A bus cycle is never a read and a write at the same time.
- R5: The first status read comes at least SETUP_DLY cycles after the 0x00D0 write. Status is fetched only with plain reads of the start address, and no command word is written after mode entry.
- R6: A group's first word is written only when the most recent status read had bit 7 = 0 and bit 0 = 1.
- R7: If a status read shows bit 4 = 1, the run ends with err_code 3, with cause_locked equal to status bit 1 and cause_supply equal to status bit 3. Both cause flags are 0 in every other outcome.
- R8: Payload word i is written to start address + i, carrying the i-th word accepted on the input stream, in stream order.
- R9: Every group holds exactly 32 words. Positions at or beyond the count are written as 0xFFFF.
- R10: If no status read meets the condition being waited for within TIMEOUT cycles, the run ends with err_code 4.
- R11: After the last group, the sequencer waits for status bit 7 = 0 with bit 0 = 1. It then writes 0xFFFF once to an address in the next block, and polls until bit 7 = 1. Only then does it end with err_code 0.
- R12: in_ready is high only while a real payload word (index below the count) is due. Exactly count words are taken from the stream.
- R13: done is high for exactly one cycle per request. busy is high from acceptance through that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_go | input | 1 | Start strobe, taken while idle |
| req_blk | input | ADDR_W | Any address inside the target block |
| req_start | input | ADDR_W | First payload address |
| req_count | input | BLK_W+1 | Number of payload words |
| in_data | input | DATA_W | Payload stream data |
| in_valid | input | 1 | Payload stream valid |
| in_ready | output | 1 | Payload stream ready |
| bus_addr | output | ADDR_W | Device address |
| bus_wdata | output | DATA_W | Device write data |
| bus_we | output | 1 | Device write strobe |
| bus_re | output | 1 | Device read strobe, data returned the next cycle |
| bus_rdata | input | DATA_W | Device read data, status in bits [7:0] |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 3 | 0 ok, 1 misaligned, 2 range, 3 device fail, 4 timeout |
| cause_locked | output | 1 | Status bit 1 seen with a device failure |
| cause_supply | output | 1 | Status bit 3 seen with a device failure |

## Verification
Every cycle, the assertions watch the following. Reads and writes never overlap. The first read respects the setup gap. Each group's first word is gated by a good status read. Refused requests stay off the bus. A successful finish is always preceded by the exit write outside the block. done never lasts two cycles. Payload order and addresses, the 0xFFFF padding, the exact number of words taken from the stream, and the error codes with their cause flags are shown only by the bench's scenarios. These run against a behavioural device model that reports busy periods, a locked block, a bad supply, and a buffer that never frees.

// File: rtl/bep_pkg.sv
package bep_pkg;

    localparam int GRP_LOG   = 5;
    localparam int GRP_WORDS = 1 << GRP_LOG;

    localparam logic [15:0] CMD_SETUP   = 16'h0080;
    localparam logic [15:0] CMD_CONFIRM = 16'h00D0;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_CONFIRM,
        ST_WAIT,
        ST_RD,
        ST_CAP,
        ST_LOAD,
        ST_EXIT,
        ST_DONE
    } bep_state_e;

    typedef enum logic [1:0] {
        PK_GROUP,
        PK_EXIT,
        PK_FINAL
    } poll_kind_e;

    typedef enum logic [2:0] {
        ERR_NONE  = 3'd0,
        ERR_ALIGN = 3'd1,
        ERR_RANGE = 3'd2,
        ERR_DEV   = 3'd3,
        ERR_TMO   = 3'd4
    } bep_err_e;

    typedef struct packed {
        logic ready;
        logic fail;
        logic supply;
        logic lock;
        logic avail;
    } bep_stat_t;

    function automatic bep_stat_t decode_stat(input logic [7:0] s);
        bep_stat_t r;
        r.ready  = s[7];
        r.fail   = s[4];
        r.supply = s[3];
        r.lock   = s[1];
        r.avail  = s[0];
        return r;
    endfunction

    function automatic logic poll_met(input poll_kind_e k, input bep_stat_t s);
        if (k == PK_FINAL) return s.ready;
        return !s.ready && s.avail;
    endfunction

endpackage

// File: rtl/bep_req_check.sv
module bep_req_check
    import bep_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BLK_W  = 8,
    localparam int CNT_W = BLK_W + 1
) (
    input  logic [ADDR_W-1:0] blk,
    input  logic [ADDR_W-1:0] start,
    input  logic [CNT_W-1:0]  count,
    output bep_err_e          verdict
);
    localparam logic [CNT_W:0] LIMIT = (CNT_W+1)'(1) << BLK_W;

    logic [CNT_W:0] reach;
    logic           unused_blk_lo;

    assign unused_blk_lo = ^blk[BLK_W-1:0];
    assign reach = (CNT_W+1)'(start[BLK_W-1:0]) + (CNT_W+1)'(count);

    always_comb begin
        if (start[GRP_LOG-1:0] != '0)
            verdict = ERR_ALIGN;
        else if (start[ADDR_W-1:BLK_W] != blk[ADDR_W-1:BLK_W] ||
                 count == '0 || reach > LIMIT)
            verdict = ERR_RANGE;
        else
            verdict = ERR_NONE;
    end
endmodule

// File: rtl/bep_timer.sv
module bep_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] value,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= value;
        else if (dec && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/bep_word_ctr.sv
module bep_word_ctr
    import bep_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] idx,
    output logic             is_pad,
    output logic             grp_end,
    output logic             last
);
    logic [CNT_W:0] total;

    assign total   = ((CNT_W+1)'(count) + (CNT_W+1)'(GRP_WORDS - 1)) &
                     ~((CNT_W+1)'(GRP_WORDS - 1));
    assign is_pad  = (idx >= count);
    assign grp_end = (idx[GRP_LOG-1:0] == '1);
    assign last    = ((CNT_W+1)'(idx) + 1'b1 == total);

    always_ff @(posedge clk) begin
        if (rst || clr)
            idx <= '0;
        else if (adv)
            idx <= idx + 1'b1;
    end
endmodule

// File: rtl/bep_stream_host.sv
module bep_stream_host
    import bep_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    parameter int BLK_W     = 8,
    parameter int SETUP_DLY = 8,
    parameter int POLL_GAP  = 2,
    parameter int TIMEOUT   = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_go,
    input  logic [ADDR_W-1:0] req_blk,
    input  logic [ADDR_W-1:0] req_start,
    input  logic [BLK_W:0]    req_count,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_we,
    output logic              bus_re,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              busy,
    output logic              done,
    output logic [2:0]        err_code,
    output logic              cause_locked,
    output logic              cause_supply
);
    localparam int CNT_W   = BLK_W + 1;
    localparam int HI_W    = ADDR_W - BLK_W;
    localparam int DLY_MAX = (SETUP_DLY > POLL_GAP) ? SETUP_DLY : POLL_GAP;
    localparam int DLY_W   = $clog2(DLY_MAX + 1);
    localparam int TO_W    = $clog2(TIMEOUT + 1);
    localparam logic [DATA_W-1:0] PAD = '1;

    bep_state_e       st;
    poll_kind_e       pk;
    bep_err_e         err_r;
    bep_err_e         verdict;
    bep_stat_t        stat;
    logic [HI_W-1:0]  blk_r;
    logic [ADDR_W-1:0] start_r;
    logic [CNT_W-1:0] cnt_r;
    logic [CNT_W-1:0] idx;
    logic             is_pad, grp_end, last;
    logic             adv;
    logic             dly_load, dly_zero;
    logic [DLY_W-1:0] dly_val;
    logic             tmo_load, tmo_dec, tmo_zero;
    logic             met;
    logic [ADDR_W-1:0] exit_addr;

    generate
        if (DATA_W > 8) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^bus_rdata[DATA_W-1:8];
        end
    endgenerate

    bep_req_check #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_check (
        .blk    (req_blk),
        .start  (req_start),
        .count  (req_count),
        .verdict(verdict)
    );

    bep_word_ctr #(.CNT_W(CNT_W)) u_words (
        .clk    (clk),
        .rst    (rst),
        .clr    (st == ST_IDLE),
        .adv    (adv),
        .count  (cnt_r),
        .idx    (idx),
        .is_pad (is_pad),
        .grp_end(grp_end),
        .last   (last)
    );

    bep_timer #(.W(DLY_W)) u_dly (
        .clk  (clk),
        .rst  (rst),
        .load (dly_load),
        .value(dly_val),
        .dec  (st == ST_WAIT),
        .zero (dly_zero)
    );

    bep_timer #(.W(TO_W)) u_tmo (
        .clk  (clk),
        .rst  (rst),
        .load (tmo_load),
        .value(TO_W'(TIMEOUT)),
        .dec  (tmo_dec),
        .zero (tmo_zero)
    );

    assign stat      = decode_stat(bus_rdata[7:0]);
    assign met       = poll_met(pk, stat);
    assign exit_addr = {blk_r + 1'b1, {BLK_W{1'b0}}};

    assign bus_re   = (st == ST_RD);
    assign bus_we   = (st == ST_SETUP) || (st == ST_CONFIRM) || (st == ST_EXIT) ||
                      (st == ST_LOAD && (is_pad || in_valid));
    assign in_ready = (st == ST_LOAD) && !is_pad;
    assign adv      = (st == ST_LOAD) && bus_we;
    assign busy     = (st != ST_IDLE);
    assign done     = (st == ST_DONE);
    assign err_code = err_r;

    always_comb begin
        bus_addr  = start_r;
        bus_wdata = '0;
        case (st)
            ST_SETUP:   bus_wdata = DATA_W'(CMD_SETUP);
            ST_CONFIRM: bus_wdata = DATA_W'(CMD_CONFIRM);
            ST_LOAD: begin
                bus_addr  = start_r + ADDR_W'(idx);
                bus_wdata = is_pad ? PAD : in_data;
            end
            ST_EXIT: begin
                bus_addr  = exit_addr;
                bus_wdata = PAD;
            end
            default: ;
        endcase
    end

    always_comb begin
        dly_load = 1'b0;
        dly_val  = DLY_W'(POLL_GAP);
        tmo_load = 1'b0;
        tmo_dec  = (st == ST_WAIT) || (st == ST_RD) || (st == ST_CAP);
        case (st)
            ST_CONFIRM: begin
                dly_load = 1'b1;
                dly_val  = DLY_W'(SETUP_DLY);
                tmo_load = 1'b1;
            end
            ST_CAP:  dly_load = !stat.fail && !met;
            ST_LOAD: begin
                dly_load = adv && (last || grp_end);
                tmo_load = adv && (last || grp_end);
            end
            ST_EXIT: begin
                dly_load = 1'b1;
                tmo_load = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= ST_IDLE;
            pk           <= PK_GROUP;
            err_r        <= ERR_NONE;
            blk_r        <= '0;
            start_r      <= '0;
            cnt_r        <= '0;
            cause_locked <= 1'b0;
            cause_supply <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (req_go) begin
                    err_r        <= verdict;
                    cause_locked <= 1'b0;
                    cause_supply <= 1'b0;
                    blk_r        <= req_blk[ADDR_W-1:BLK_W];
                    start_r      <= req_start;
                    cnt_r        <= req_count;
                    pk           <= PK_GROUP;
                    st           <= (verdict == ERR_NONE) ? ST_SETUP : ST_DONE;
                end
                ST_SETUP:   st <= ST_CONFIRM;
                ST_CONFIRM: st <= ST_WAIT;
                ST_WAIT:    if (dly_zero) st <= ST_RD;
                ST_RD:      st <= ST_CAP;
                ST_CAP: begin
                    if (stat.fail) begin
                        err_r        <= ERR_DEV;
                        cause_locked <= stat.lock;
                        cause_supply <= stat.supply;
                        st           <= ST_DONE;
                    end else if (met) begin
                        case (pk)
                            PK_GROUP: st <= ST_LOAD;
                            PK_EXIT:  st <= ST_EXIT;
                            default:  st <= ST_DONE;
                        endcase
                    end else if (tmo_zero) begin
                        err_r <= ERR_TMO;
                        st    <= ST_DONE;
                    end else begin
                        st <= ST_WAIT;
                    end
                end
                ST_LOAD: if (adv) begin
                    if (last) begin
                        pk <= PK_EXIT;
                        st <= ST_WAIT;
                    end else if (grp_end) begin
                        pk <= PK_GROUP;
                        st <= ST_WAIT;
                    end
                end
                ST_EXIT: begin
                    pk <= PK_FINAL;
                    st <= ST_WAIT;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bep_stream_host_chk.sv
module bep_stream_host_chk #(
    parameter int ADDR_W    = 16,
    parameter int BLK_W     = 8,
    parameter int SETUP_DLY = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    req_go,
    input logic [ADDR_W-BLK_W-1:0] req_hi,
    input logic [ADDR_W-BLK_W-1:0] bus_hi,
    input logic                    bus_we,
    input logic                    bus_re,
    input logic [7:0]              rd_stat,
    input logic                    in_ready,
    input logic                    busy,
    input logic                    done,
    input logic [2:0]              err_code,
    input logic                    cause_locked,
    input logic                    cause_supply
);
    logic [15:0]             wcnt;
    logic [15:0]             gap;
    logic                    first_rd;
    logic                    re_d;
    logic                    last_ok;
    logic                    exit_seen;
    logic [ADDR_W-BLK_W-1:0] blk_q;
    logic                    accept;

    assign accept = req_go && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt <= '0; gap <= '0; first_rd <= 1'b0; re_d <= 1'b0;
            last_ok <= 1'b0; exit_seen <= 1'b0; blk_q <= '0;
        end else begin
            re_d <= bus_re;
            if (accept) wcnt <= '0;
            else if (bus_we) wcnt <= wcnt + 1'b1;
            if (bus_we && wcnt == 16'd1) gap <= '0;
            else if (gap != '1) gap <= gap + 1'b1;
            if (bus_we && wcnt == 16'd1) first_rd <= 1'b1;
            else if (bus_re) first_rd <= 1'b0;
            if (accept) last_ok <= 1'b0;
            else if (re_d) last_ok <= !rd_stat[7] && rd_stat[0];
            if (accept) begin
                exit_seen <= 1'b0;
                blk_q     <= req_hi;
            end else if (bus_we && bus_hi != blk_q) begin
                exit_seen <= 1'b1;
            end
        end
    end

    a_r4_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_re));

    a_r5_setup_gap: assert property (@(posedge clk) disable iff (rst)
        (bus_re && first_rd) |-> (gap >= 16'(SETUP_DLY)));

    a_r6_group_gate: assert property (@(posedge clk) disable iff (rst)
        (bus_we && wcnt >= 16'd2 && wcnt[4:0] == 5'd2) |-> last_ok);

    a_r2_r3_quiet_reject: assert property (@(posedge clk) disable iff (rst)
        (done && (err_code == 3'd1 || err_code == 3'd2)) |-> (wcnt == '0));

    a_r7_cause_only_fail: assert property (@(posedge clk) disable iff (rst)
        (done && (cause_locked || cause_supply)) |-> (err_code == 3'd3));

    a_r11_exit_first: assert property (@(posedge clk) disable iff (rst)
        (done && err_code == 3'd0) |-> exit_seen);

    a_r12_ready_busy: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> busy);

    a_r13_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

bind bep_stream_host bep_stream_host_chk #(
    .ADDR_W   (ADDR_W),
    .BLK_W    (BLK_W),
    .SETUP_DLY(SETUP_DLY)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_go      (req_go),
    .req_hi      (req_blk[ADDR_W-1:BLK_W]),
    .bus_hi      (bus_addr[ADDR_W-1:BLK_W]),
    .bus_we      (bus_we),
    .bus_re      (bus_re),
    .rd_stat     (bus_rdata[7:0]),
    .in_ready    (in_ready),
    .busy        (busy),
    .done        (done),
    .err_code    (err_code),
    .cause_locked(cause_locked),
    .cause_supply(cause_supply)
);

// File: tb/bep_stream_host_bench.sv
`timescale 1ns/1ps
module bep_stream_host_bench;
    localparam int B_DLY = 8;
    localparam logic [15:0] BLK_BASE = 16'h0300;

    // vector: off[20:13] cnt[12:4] code[3:1] stall[0]
    localparam logic [20:0] VEC [0:7] = '{
        {8'd0,   9'd32,  3'd0, 1'b0},
        {8'd32,  9'd5,   3'd0, 1'b1},
        {8'd64,  9'd70,  3'd0, 1'b0},
        {8'd0,   9'd256, 3'd0, 1'b0},
        {8'd3,   9'd10,  3'd1, 1'b0},
        {8'd224, 9'd33,  3'd2, 1'b0},
        {8'd0,   9'd0,   3'd2, 1'b0},
        {8'd224, 9'd32,  3'd0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_go = 1'b0;
    logic [15:0] req_blk = '0, req_start = '0;
    logic [8:0]  req_count = '0;
    logic [15:0] in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] bus_addr, bus_wdata, bus_rdata;
    logic        bus_we, bus_re, busy, done, cause_locked, cause_supply;
    logic [2:0]  err_code;

    int total = 0, bad = 0;
    int src_i = 0, cyc_n = 0, cyc_p = 0;
    bit src_on = 0, stall_en = 0, m_clr = 0;
    bit m_locked = 0, m_vpp = 0, m_noready = 0;
    logic [15:0] la [0:299];
    logic [15:0] ld [0:299];
    int n_w = 0, phase = 0, bufc = 0, tmr = 0, exits = 0, overrun = 0;
    int conf_cyc = 0, first_rd = -1;
    logic [7:0] stat = '0, pend = '0, mblk = '0;

    always #10 clk = ~clk;

    bep_stream_host #(.SETUP_DLY(B_DLY), .POLL_GAP(2), .TIMEOUT(64)) u_bep_stream_host (
        .clk(clk), .rst(rst), .req_go(req_go), .req_blk(req_blk),
        .req_start(req_start), .req_count(req_count), .in_data(in_data),
        .in_valid(in_valid), .in_ready(in_ready), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
        .bus_rdata(bus_rdata), .busy(busy), .done(done), .err_code(err_code),
        .cause_locked(cause_locked), .cause_supply(cause_supply)
    );

    // behavioural device model
    always @(posedge clk) begin
        cyc_p++;
        if (m_clr) begin
            n_w = 0; phase = 0; bufc = 0; tmr = 0; exits = 0; overrun = 0;
            stat = '0; src_i = 0; first_rd = -1;
            bus_rdata <= '0;
        end else begin
            if (bus_re) begin
                bus_rdata <= {8'h00, stat};
                if (first_rd < 0) first_rd = cyc_p;
            end
            if (tmr != 0) begin
                if (tmr == 1) stat = pend;
                tmr--;
            end
            if (bus_we) begin
                if (n_w < 300) begin la[n_w] = bus_addr; ld[n_w] = bus_wdata; end
                n_w++;
                case (phase)
                    0: if (bus_wdata == 16'h0080) begin phase = 1; mblk = bus_addr[15:8]; end
                    1: if (bus_wdata == 16'h00D0) begin
                        conf_cyc = cyc_p;
                        if (m_locked) begin stat = 8'h92; phase = 0; end
                        else if (m_vpp) begin stat = 8'h98; phase = 0; end
                        else begin
                            stat = 8'h00; phase = 2;
                            if (!m_noready) begin tmr = 5; pend = 8'h01; end
                        end
                    end
                    2: if (bus_addr[15:8] != mblk) begin
                        stat = 8'h00; tmr = 4; pend = 8'h80; phase = 0; exits++;
                    end else begin
                        if (!stat[0]) overrun++;
                        bufc++;
                        if (bufc == 32) begin bufc = 0; stat = 8'h00; tmr = 6; pend = 8'h01; end
                    end
                    default: ;
                endcase
            end
            if (in_valid && in_ready) src_i++;
        end
    end

    always @(negedge clk) begin
        cyc_n++;
        in_data  = 16'hC000 + src_i[15:0];
        in_valid = src_on && !(stall_en && (cyc_n % 3 == 0));
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic run_case(input int off, input int cnt, input int code, input bit stall,
                            input bit same_blk, input bit lk, input bit vp, input bit nr);
        int waited;
        int groups;
        int nbad;
        logic [15:0] first_a, first_e;
        logic [15:0] st_addr;
        m_locked = lk; m_vpp = vp; m_noready = nr;
        m_clr = 1; src_on = 0;
        @(negedge clk);
        m_clr = 0; stall_en = stall; src_on = 1;
        st_addr   = (same_blk ? BLK_BASE : BLK_BASE + 16'h0100) + 16'(off);
        req_blk   = BLK_BASE;
        req_start = st_addr;
        req_count = 9'(cnt);
        req_go    = 1;
        @(negedge clk);
        req_go = 0;
        waited = 0;
        while (!done && waited < 6000) begin
            @(negedge clk);
            waited++;
        end
        check(done, "R13 done seen", 32'(done), 1);
        check(err_code == 3'(code), "R2 R3 R7 R10 R11 err_code", 32'(err_code), 32'(code));
        check(cause_locked == lk && cause_supply == vp, "R7 cause flags",
              {cause_locked, cause_supply}, {lk, vp});
        @(negedge clk);
        check(!done && !busy, "R13 done one cycle", {done, busy}, 0);
        if (code == 1 || code == 2) begin
            check(n_w == 0 && first_rd < 0, "R2 R3 no bus cycle", 32'(n_w), 0);
        end else if (code == 0) begin
            groups = (cnt + 31) / 32;
            check(n_w == 3 + 32 * groups, "R9 write count", 32'(n_w), 32'(3 + 32 * groups));
            check(ld[0] == 16'h0080 && ld[1] == 16'h00D0 && la[0] == st_addr && la[1] == st_addr,
                  "R4 entry writes", {ld[0], ld[1]}, 32'h008000D0);
            check(first_rd - conf_cyc >= B_DLY, "R5 setup gap", 32'(first_rd - conf_cyc), B_DLY);
            nbad = 0; first_a = '0; first_e = '0;
            for (int i = 0; i < 32 * groups; i++) begin
                logic [15:0] ed;
                ed = (i < cnt) ? 16'hC000 + 16'(i) : 16'hFFFF;
                if (ld[2+i] != ed || la[2+i] != st_addr + 16'(i)) begin
                    if (nbad == 0) begin first_a = ld[2+i]; first_e = ed; end
                    nbad++;
                end
            end
            check(nbad == 0, "R8 R9 payload and padding", {16'(nbad), first_a}, {16'h0, first_e});
            check(overrun == 0, "R6 group gated by status", 32'(overrun), 0);
            check(exits == 1 && la[n_w-1][15:8] != BLK_BASE[15:8] && ld[n_w-1] == 16'hFFFF,
                  "R11 exit write", {16'(exits), la[n_w-1]}, 32'h1_0400);
            check(src_i == cnt, "R12 words consumed", 32'(src_i), 32'(cnt));
        end else begin
            check(n_w == 2, "R10 R7 no payload after failure", 32'(n_w), 2);
            check(src_i == 0, "R12 nothing consumed", 32'(src_i), 0);
        end
        src_on = 0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !bus_we && !bus_re && !in_ready, "R1 reset outputs",
              {busy, done, bus_we, bus_re, in_ready}, 0);
        rst = 0;
        @(negedge clk);
        check(!busy && !done && !bus_we && !bus_re && !in_ready, "R1 after reset",
              {busy, done, bus_we, bus_re, in_ready}, 0);
        for (int v = 0; v < 8; v++) begin
            run_case(int'(VEC[v][20:13]), int'(VEC[v][12:4]), int'(VEC[v][3:1]), VEC[v][0],
                     1'b1, 1'b0, 1'b0, 1'b0);
        end
        // R3: start in another block
        run_case(0, 8, 2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        // R7: locked block, then bad supply
        run_case(0, 40, 3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        run_case(32, 8, 3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        // R10: buffer never available
        run_case(0, 16, 4, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        // back-to-back recovery after an error
        run_case(96, 1, 0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule